// File: doc/BRIEF.md
# Two-Channel Split-Phase PWM Generator

This block produces two independent pulse-width-modulated outputs. Each waveform is set by two counts: how many divided ticks the output stays high, followed by how many it stays low. The cycle then repeats. The period is therefore the sum of the two counts, not a period register with a compare threshold.

Each channel picks one of four timing sources, which arrive as single-cycle strobes in the system clock domain. It thins that source by a 7-bit pre-divider, so the channel advances once every N+1 selected strobes. Software programs the block through a simple word-addressed read/write port with three registers: one phase-count word per channel and one shared control word. Count changes made while a channel runs are held back until its current period ends.

Top module: `duo_phase_pwm`

## Requirements
- R1: After reset every register reads zero and both outputs are low.
- R2: Each channel has a phase-count word. Channel 0's word is at address 0x0 and channel 1's at 0x4. Bits 31:16 of the word are the high count and bits 15:0 are the low count. The control word is at 0x8 and reads back only its defined bits (mask 0x00FFFFF3), with undefined bits reading zero. Any other address reads zero, and a write to it changes no register.
- R3: The control word holds these fields for each channel:
  - Output enable: bit 0 for channel 0, bit 1 for channel 1.
  - Source select: bits 5:4 for channel 0, bits 7:6 for channel 1.
  - Pre-divider: bits 14:8 for channel 0, bits 22:16 for channel 1.
  - Tick gate: bit 15 for channel 0, bit 23 for channel 1.
- R4: A channel counts only strobes on the source line its select field names (lines 0 to 3). Strobes on the other lines have no effect on its output.
- R5: With pre-divider value N, a channel advances once on every (N+1)-th selected strobe counted from its enable.
- R6: From enable, the output is high for the high count of advances, then low for the low count of advances, and this repeats. With K advances since enable and a constant period P = high + low, the output is high exactly when (K mod P) < high.
- R7: A high count of zero keeps the output low. A low count of zero keeps it high. Both counts at zero keep it low.
- R8: While a channel's output enable is clear, its output is low and its divider and phase position are cleared. Enabling it again starts a fresh high phase.
- R9: While a channel's tick gate is clear, the channel does not advance and its output holds the value of its first phase.
- R10: Counts written while a channel runs take effect only at the next period boundary. The phase in progress keeps the old counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_tick | input | 4 | Four timing-source strobes, one cycle wide |
| pwm_out | output | 2 | Channel outputs, bit 0 for channel 0 |

## Verification
Read data follows bus_addr in the same cycle, and a write shows in read data after the edge that takes it. A selected strobe changes the output on the very edge that consumes it, because the divider tick feeds the registered output directly. An enable or disable write needs two edges to reach the pin: one to load the control word and one for the output register. The bench drives every input on the falling edge and samples on the next falling edge, one edge after each strobe. After a control write it waits one further falling edge before it compares the output against the value computed arithmetically from the count of selected strobes.

// File: rtl/dpp_pkg.sv
package dpp_pkg;
    localparam int CNT_W   = 16;
    localparam int DIV_W   = 7;
    localparam int SEL_W   = 2;
    localparam int NSRC    = 1 << SEL_W;
    localparam int NCH     = 2;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int POS_W   = CNT_W + 1;
    localparam int CTRL_ADDR = 4 * NCH;

    typedef struct packed {
        logic             en;
        logic             gate;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } chan_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } phase_cnt_t;

    function automatic int en_bit(input int ch);
        return ch;
    endfunction

    function automatic int sel_lsb(input int ch);
        return 4 + SEL_W * ch;
    endfunction

    function automatic int div_lsb(input int ch);
        return 8 + 8 * ch;
    endfunction

    function automatic int gate_bit(input int ch);
        return 15 + 8 * ch;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            m[en_bit(ch)]   = 1'b1;
            m[gate_bit(ch)] = 1'b1;
            for (int b = 0; b < SEL_W; b++) m[sel_lsb(ch) + b] = 1'b1;
            for (int b = 0; b < DIV_W; b++) m[div_lsb(ch) + b] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/dpp_regfile.sv
module dpp_regfile
    import dpp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output phase_cnt_t [NCH-1:0]    cnt_o,
    output chan_cfg_t  [NCH-1:0]    cfg_o
);
    localparam logic [DATA_W-1:0] MASK = ctrl_mask();

    typedef struct packed {
        phase_cnt_t [NCH-1:0] cnt;
        logic [DATA_W-1:0]    ctrl;
    } rf_state_t;

    rf_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (bus_wr) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (bus_addr == ADDR_W'(4 * ch)) s_d.cnt[ch] = bus_wdata;
            end
            if (bus_addr == ADDR_W'(CTRL_ADDR)) s_d.ctrl = bus_wdata & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (bus_addr == ADDR_W'(4 * ch)) bus_rdata = s_q.cnt[ch];
        end
        if (bus_addr == ADDR_W'(CTRL_ADDR)) bus_rdata = s_q.ctrl;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_field
        localparam int EB = en_bit(ch);
        localparam int SL = sel_lsb(ch);
        localparam int DL = div_lsb(ch);
        localparam int GB = gate_bit(ch);
        assign cnt_o[ch]      = s_q.cnt[ch];
        assign cfg_o[ch].en   = s_q.ctrl[EB];
        assign cfg_o[ch].gate = s_q.ctrl[GB];
        assign cfg_o[ch].sel  = s_q.ctrl[SL +: SEL_W];
        assign cfg_o[ch].div  = s_q.ctrl[DL +: DIV_W];

        // R2
        cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(4 * ch)) |=> (cnt_o[ch] == $past(bus_wdata)))
            else $error("count word write not stored");
    end

    // R2
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(CTRL_ADDR)) |=> (s_q.ctrl == ($past(bus_wdata) & MASK)))
        else $error("control write not stored");
endmodule

// File: rtl/dpp_prescaler.sv
module dpp_prescaler
    import dpp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  chan_cfg_t       cfg_i,
    output logic            tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } ps_state_t;

    ps_state_t s_d, s_q;
    logic active, sel_tick;

    always_comb begin
        active   = cfg_i.en && cfg_i.gate;
        sel_tick = src_i[cfg_i.sel];
        tick_o   = active && sel_tick && (s_q.cnt >= cfg_i.div);
        s_d      = s_q;
        if (!active)       s_d.cnt = '0;
        else if (tick_o)   s_d.cnt = '0;
        else if (sel_tick) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> (s_q.cnt == '0))
        else $error("divider not cleared while disabled");

    // R5
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (s_q.cnt == '0))
        else $error("divider did not restart after tick");

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.gate |=> (s_q.cnt == '0))
        else $error("divider moved with gate clear");
endmodule

// File: rtl/dpp_wavegen.sv
module dpp_wavegen
    import dpp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       tick_i,
    input  phase_cnt_t cnt_i,
    output logic       out_o
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic             out;
    } wg_state_t;

    wg_state_t s_d, s_q;
    logic [POS_W-1:0] period_q, pos_inc;

    always_comb begin
        period_q = {1'b0, s_q.hi} + {1'b0, s_q.lo};
        pos_inc  = s_q.pos + 1'b1;
        s_d      = s_q;
        if (!en_i) begin
            s_d.pos = '0;
            s_d.hi  = cnt_i.hi;
            s_d.lo  = cnt_i.lo;
        end else if (tick_i) begin
            if (pos_inc >= period_q) begin
                s_d.pos = '0;
                s_d.hi  = cnt_i.hi;
                s_d.lo  = cnt_i.lo;
            end else begin
                s_d.pos = pos_inc;
            end
        end
        s_d.out = en_i && (s_d.pos < {1'b0, s_d.hi});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_o = s_q.out;

    // R8
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !out_o)
        else $error("output high while disabled");

    // R6
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> ((s_q.pos < period_q) || (s_q.pos == '0)))
        else $error("phase position beyond period");

    // R10
    mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> ($stable(s_q.hi) && $stable(s_q.lo)))
        else $error("counts changed inside a period");
endmodule

// File: rtl/duo_phase_pwm.sv
module duo_phase_pwm
    import dpp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        src_tick,
    output logic [1:0]        pwm_out
);
    phase_cnt_t [NCH-1:0] cnt_w;
    chan_cfg_t  [NCH-1:0] cfg_w;
    logic       [NCH-1:0] tick_w;

    dpp_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_o     (cnt_w),
        .cfg_o     (cfg_w)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        dpp_prescaler u_ps (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_tick),
            .cfg_i  (cfg_w[ch]),
            .tick_o (tick_w[ch])
        );

        dpp_wavegen u_wg (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (cfg_w[ch].en),
            .tick_i (tick_w[ch]),
            .cnt_i  (cnt_w[ch]),
            .out_o  (pwm_out[ch])
        );
    end
endmodule

// File: tb/duo_phase_pwm_tb.sv
`timescale 1ns/1ps
module duo_phase_pwm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = '0;
    logic [1:0]  pwm_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    duo_phase_pwm dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_tick  (src_tick),
        .pwm_out   (pwm_out)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input int ea, input int ga, input int sa, input int da,
                                            input int eb, input int gb, input int sb, input int db);
        logic [31:0] c;
        c = '0;
        c[0] = ea[0]; c[1] = eb[0];
        c[5:4] = sa[1:0]; c[7:6] = sb[1:0];
        c[14:8] = da[6:0]; c[15] = ga[0];
        c[22:16] = db[6:0]; c[23] = gb[0];
        return c;
    endfunction

    function automatic logic exp_out(input int n, input int dv, input int h, input int l);
        if (h + l == 0) return 1'b0;
        return ((n / (dv + 1)) % (h + l)) < h;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(4'h0, d); check("R1 cnt0", d, 32'h0);
        rd(4'h4, d); check("R1 cnt1", d, 32'h0);
        rd(4'h8, d); check("R1 ctrl", d, 32'h0);
        check("R1 out", {30'h0, pwm_out}, 32'h0);

        // R2: map and readback
        wr(4'h0, 32'h1234_5678);
        wr(4'h4, 32'h9ABC_DEF0);
        wr(4'hC, 32'h0000_00FF);
        rd(4'h0, d); check("R2 cnt0", d, 32'h1234_5678);
        rd(4'h4, d); check("R2 cnt1", d, 32'h9ABC_DEF0);
        rd(4'hC, d); check("R2 unmapped", d, 32'h0);
        rd(4'h8, d); check("R2 ctrl untouched", d, 32'h0);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, d); check("R2 ctrl mask", d, 32'h00FF_FFF3);
        wr(4'h8, 32'h0);

        // R9: gate clear holds first phase
        wr(4'h0, {16'd1, 16'd1});
        wr(4'h8, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            src_tick = 4'hF;
            @(negedge clk);
            check("R9 gate off hold", {31'h0, pwm_out[0]}, 32'h1);
        end
        src_tick = '0;
        wr(4'h8, 32'h0);
        @(negedge clk);
        check("R8 off low", {30'h0, pwm_out}, 32'h0);

        // R10: counts latched at period boundary
        wr(4'h0, {16'd2, 16'd2});
        wr(4'h8, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        check("R10 start", {31'h0, pwm_out[0]}, 32'h1);
        src_tick = 4'h1;
        @(negedge clk);
        src_tick = '0;
        check("R10 pos1", {31'h0, pwm_out[0]}, 32'h1);
        wr(4'h0, {16'd3, 16'd1});
        check("R10 after write", {31'h0, pwm_out[0]}, 32'h1);
        @(negedge clk);
        check("R10 idle", {31'h0, pwm_out[0]}, 32'h1);
        begin
            logic [6:0] seq;
            seq = 7'b1011100; // index 0 is first: 0,0,1,1,1,0,1
            for (int i = 0; i < 7; i++) begin
                src_tick = 4'h1;
                @(negedge clk);
                check("R10 sequence", {31'h0, pwm_out[0]}, {31'h0, seq[i]});
            end
        end
        src_tick = '0;
        wr(4'h8, 32'h0);

        // R3 R4 R5 R6 R7 R8: sweep of both channels
        for (int s = 0; s < 4; s++)
        for (int dv = 0; dv < 3; dv++)
        for (int h = 0; h < 4; h++)
        for (int l = 0; l < 4; l++) begin
            int sb, db, na, nb, len;
            sb = 3 - s; db = 2 - dv; na = 0; nb = 0;
            len = 4 * 3 * (h + l + 1) + 4;
            wr(4'h8, 32'h0);
            wr(4'h0, {16'(h), 16'(l)});
            wr(4'h4, {16'(l), 16'(h)});
            wr(4'h8, mk_ctrl(1, 1, s, dv, 1, 1, sb, db));
            @(negedge clk);
            for (int k = 0; k < len; k++) begin
                logic [3:0] r;
                check("R6 R7 ch0 wave", {31'h0, pwm_out[0]}, {31'h0, exp_out(na, dv, h, l)});
                check("R3 R4 R5 ch1 wave", {31'h0, pwm_out[1]}, {31'h0, exp_out(nb, db, l, h)});
                r = 4'($urandom);
                src_tick = r;
                na += int'(r[s]);
                nb += int'(r[sb]);
                @(negedge clk);
            end
            src_tick = '0;
            wr(4'h8, 32'h0);
            @(negedge clk);
            check("R8 disabled low", {30'h0, pwm_out}, 32'h0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule